// File: doc/BRIEF.md
# Store-Merging Line Reload Buffer

This block is a small buffer that sits between a data cache's store path and its bus interface. It holds up to four cache lines of 32 bytes each. Every line has a per-byte written mask. A store that misses opens an entry and asks the bus side for the line. Later stores to the same line write their bytes into that entry and never open a second one. An entry for coherent space that stores cover completely tells the bus side that the fill data is no longer needed. An entry for non-coherent space that stores cover completely goes straight into the cache, with no bus response.

A write-back store that hits a line held shared or recent also passes through the buffer. The cache line is invalidated, the old line data is merged under the store bytes into a new entry, and an ownership (kill) request is raised. Once the bus side reports that the kill succeeded, the entry is written back. Fill data from the bus only lands in bytes that no store has written. Every line written back to the cache is reported in the modified state, and its entry is then released.

Top module: `stmerge_rlb`

## Requirements
- R1: A store (`st_hit_sr_i`=0) whose line matches no open entry is accepted into the lowest free entry. One cycle later `req_valid_o` pulses with `req_kill_o`=0, `req_line_o` set to the store line, and `req_id_o` set to the entry index.
- R2: A store whose line matches an open entry merges its enabled bytes (byte b is `st_data_i[8b+:8]`, enabled by `st_be_i[b]`) into that entry. It raises no new request and is accepted even when all four entries are busy.
- R3: When a store completes all 32 bytes of a coherent (`st_coh_i`=1) miss entry, `nodata_o` pulses one cycle later with that entry's index. The entry is written back only after a fill or kill-done response for it arrives.
- R4: When a store completes all 32 bytes of a non-coherent miss entry, `wr_valid_o` rises in the cycle after that store with the store data. `nodata_o` stays low.
- R5: Two consecutive stores to one line, covering the low 16 and then the high 16 bytes, complete the entry.
- R6: An accepted store with `st_hit_sr_i`=1 pulses `inv_valid_o` one cycle later, with `inv_line_o` set to the store line. In the same cycle it raises `req_valid_o` with `req_kill_o`=1. The entry data is `st_old_i` with the store bytes written over it.
- R7: An ownership-upgrade entry is written back only after `kill_done_i` arrives with its index. Every write-back reports `wr_state_o`=2'b11 (modified).
- R8: A fill response writes `fill_data_i` only into bytes that stores have not written. The entry is then written back, starting in the cycle after the fill.
- R9: With four busy entries, a store to a fifth line holds `st_ready_o` low until an entry is released.
- R10: Fill and kill-done responses that name a free entry have no effect: no write-back results.
- R11: Entries that are ready together are written back one per cycle, lowest index first. Each entry is released after its write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store present |
| st_ready_o | output | 1 | Store accepted this cycle |
| st_line_i | input | 26 | Store line address |
| st_be_i | input | 32 | Store byte enables |
| st_data_i | input | 256 | Store data, byte b at bits 8b+7:8b |
| st_coh_i | input | 1 | Store targets coherency-required space |
| st_hit_sr_i | input | 1 | Store hit a shared or recent cache line |
| st_old_i | input | 256 | Current cache line data for a shared/recent hit |
| req_valid_o | output | 1 | Bus request pulse |
| req_kill_o | output | 1 | 1: kill for ownership, 0: line read |
| req_line_o | output | 26 | Request line address |
| req_id_o | output | 2 | Entry index of the request |
| inv_valid_o | output | 1 | Invalidate cache line pulse |
| inv_line_o | output | 26 | Line to invalidate |
| nodata_o | output | 1 | Fill data no longer needed pulse |
| nodata_id_o | output | 2 | Entry whose fill data is not needed |
| fill_valid_i | input | 1 | Fill data returned |
| fill_id_i | input | 2 | Entry of the fill |
| fill_data_i | input | 256 | Fill line data |
| kill_done_i | input | 1 | Kill or dropped transaction complete |
| kill_id_i | input | 2 | Entry of the kill completion |
| wr_valid_o | output | 1 | Cache line write-back this cycle |
| wr_line_o | output | 26 | Write-back line address |
| wr_data_o | output | 256 | Write-back line data |
| wr_state_o | output | 2 | Write-back line state (2'b11 modified) |

## Verification
The main merge path is tried with four store patterns. Two halves of a non-coherent line show that an entry installs itself without any bus response. Two halves of a coherent line show that the entry waits for a response and raises the no-data signal. A partial store followed by a fill checks that store bytes win over fill bytes. A shared-hit store with a scattered byte mask checks that old data sits under the new bytes. Filling all four entries and then merging into one of them tells "match wins while full" apart from "fifth line stalls". Releasing two entries in the same cycle exposes the write-back order.

// File: rtl/stmerge_rlb_pkg.sv
package stmerge_rlb_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_state_e;
endpackage

// File: rtl/stmerge_rlb_pick.sv
module stmerge_rlb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  oh_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    oh_o  = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        oh_o  = '0;
        oh_o[i] = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/stmerge_rlb_entry.sv
module stmerge_rlb_entry #(
  parameter int LB = 32,
  parameter int AW = 26,
  localparam int DW = LB * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          alloc_upg_i,
  input  logic          alloc_coh_i,
  input  logic [AW-1:0] line_i,
  input  logic [LB-1:0] be_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [DW-1:0] old_i,
  input  logic          merge_i,
  input  logic          fill_i,
  input  logic [DW-1:0] fill_data_i,
  input  logic          kill_i,
  input  logic          install_i,
  output logic          busy_o,
  output logic [AW-1:0] line_o,
  output logic [DW-1:0] data_o,
  output logic          ready_o,
  output logic          full_now_o
);
  logic          busy_q, upg_q, coh_q, resp_q;
  logic [AW-1:0] line_q;
  logic [LB-1:0] mask_q, mask_n;
  logic [DW-1:0] data_q, data_n, alloc_data;
  logic          mask_full, resp_n;

  assign mask_full = &mask_q;
  assign ready_o   = busy_q && (upg_q ? resp_q : (mask_full && (!coh_q || resp_q)));
  // store completes a coherent miss line: fill data becomes pointless
  assign full_now_o = busy_q && merge_i && !upg_q && coh_q && !mask_full && (&(mask_q | be_i));

  always_comb begin
    mask_n = mask_q | (merge_i ? be_i : '0);
    resp_n = resp_q | fill_i | kill_i;
    data_n = data_q;
    for (int b = 0; b < LB; b++) begin
      if (merge_i && be_i[b])
        data_n[8*b +: 8] = st_data_i[8*b +: 8];
      else if (fill_i && !mask_q[b])
        data_n[8*b +: 8] = fill_data_i[8*b +: 8];
      alloc_data[8*b +: 8] = be_i[b] ? st_data_i[8*b +: 8]
                                     : (alloc_upg_i ? old_i[8*b +: 8] : 8'h00);
    end
    if (fill_i) mask_n = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      upg_q  <= 1'b0;
      coh_q  <= 1'b0;
      resp_q <= 1'b0;
      line_q <= '0;
      mask_q <= '0;
      data_q <= '0;
    end else if (install_i) begin
      busy_q <= 1'b0;
      resp_q <= 1'b0;
      mask_q <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      upg_q  <= alloc_upg_i;
      coh_q  <= alloc_coh_i;
      resp_q <= 1'b0;
      line_q <= line_i;
      mask_q <= alloc_upg_i ? '1 : be_i;
      data_q <= alloc_data;
    end else if (busy_q) begin
      resp_q <= resp_n;
      mask_q <= mask_n;
      data_q <= data_n;
    end
  end

  assign busy_o = busy_q;
  assign line_o = line_q;
  assign data_o = data_q;
endmodule

// File: rtl/stmerge_rlb.sv
module stmerge_rlb #(
  parameter int N_ENT  = 4,
  parameter int LINE_B = 32,
  parameter int AW     = 26,
  localparam int DW = LINE_B * 8,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [AW-1:0]     st_line_i,
  input  logic [LINE_B-1:0] st_be_i,
  input  logic [DW-1:0]     st_data_i,
  input  logic              st_coh_i,
  input  logic              st_hit_sr_i,
  input  logic [DW-1:0]     st_old_i,
  output logic              req_valid_o,
  output logic              req_kill_o,
  output logic [AW-1:0]     req_line_o,
  output logic [IW-1:0]     req_id_o,
  output logic              inv_valid_o,
  output logic [AW-1:0]     inv_line_o,
  output logic              nodata_o,
  output logic [IW-1:0]     nodata_id_o,
  input  logic              fill_valid_i,
  input  logic [IW-1:0]     fill_id_i,
  input  logic [DW-1:0]     fill_data_i,
  input  logic              kill_done_i,
  input  logic [IW-1:0]     kill_id_i,
  output logic              wr_valid_o,
  output logic [AW-1:0]     wr_line_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [1:0]        wr_state_o
);
  import stmerge_rlb_pkg::*;

  logic [N_ENT-1:0] busy, ready, match, full_now, merge_v, alloc_v;
  logic [N_ENT-1:0] free_oh, inst_oh, full_oh;
  logic [IW-1:0]    free_idx, inst_idx, full_idx;
  logic             free_any, inst_any, full_any, hit_any, accept;
  logic [AW-1:0]    ent_line [N_ENT];
  logic [DW-1:0]    ent_data [N_ENT];

  assign hit_any    = |match;
  // a line leaving this cycle cannot take more bytes
  assign st_ready_o = hit_any ? !(|(match & inst_oh)) : free_any;
  assign accept     = st_valid_i && st_ready_o;
  assign merge_v    = match & {N_ENT{accept}};
  assign alloc_v    = free_oh & {N_ENT{accept && !hit_any}};

  stmerge_rlb_pick #(.N(N_ENT), .IW(IW)) u_free (
    .req_i(~busy), .oh_o(free_oh), .idx_o(free_idx), .any_o(free_any));
  stmerge_rlb_pick #(.N(N_ENT), .IW(IW)) u_inst (
    .req_i(ready), .oh_o(inst_oh), .idx_o(inst_idx), .any_o(inst_any));
  stmerge_rlb_pick #(.N(N_ENT), .IW(IW)) u_full (
    .req_i(full_now), .oh_o(full_oh), .idx_o(full_idx), .any_o(full_any));

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign match[i] = busy[i] && (ent_line[i] == st_line_i);
    stmerge_rlb_entry #(.LB(LINE_B), .AW(AW)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_v[i]),
      .alloc_upg_i (st_hit_sr_i),
      .alloc_coh_i (st_coh_i),
      .line_i      (st_line_i),
      .be_i        (st_be_i),
      .st_data_i   (st_data_i),
      .old_i       (st_old_i),
      .merge_i     (merge_v[i]),
      .fill_i      (fill_valid_i && (fill_id_i == IW'(i))),
      .fill_data_i (fill_data_i),
      .kill_i      (kill_done_i && (kill_id_i == IW'(i))),
      .install_i   (inst_oh[i]),
      .busy_o      (busy[i]),
      .line_o      (ent_line[i]),
      .data_o      (ent_data[i]),
      .ready_o     (ready[i]),
      .full_now_o  (full_now[i])
    );
  end

  assign wr_valid_o = inst_any;
  assign wr_line_o  = ent_line[inst_idx];
  assign wr_data_o  = ent_data[inst_idx];
  assign wr_state_o = LS_MOD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o <= 1'b0;
      req_kill_o  <= 1'b0;
      req_line_o  <= '0;
      req_id_o    <= '0;
      inv_valid_o <= 1'b0;
      inv_line_o  <= '0;
      nodata_o    <= 1'b0;
      nodata_id_o <= '0;
    end else begin
      req_valid_o <= |alloc_v;
      inv_valid_o <= (|alloc_v) && st_hit_sr_i;
      nodata_o    <= full_any;
      if (|alloc_v) begin
        req_kill_o <= st_hit_sr_i;
        req_line_o <= st_line_i;
        req_id_o   <= free_idx;
        inv_line_o <= st_line_i;
      end
      if (full_any) nodata_id_o <= full_idx;
    end
  end
endmodule

module stmerge_rlb_chk #(
  parameter int N_ENT = 4,
  parameter int AW    = 26
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             st_valid_i,
  input logic             st_ready_o,
  input logic             st_coh_i,
  input logic             st_hit_sr_i,
  input logic             req_valid_o,
  input logic             req_kill_o,
  input logic [AW-1:0]    req_line_o,
  input logic             inv_valid_o,
  input logic [AW-1:0]    inv_line_o,
  input logic             nodata_o,
  input logic             wr_valid_o,
  input logic [1:0]       wr_state_o,
  input logic [N_ENT-1:0] busy_i,
  input logic [N_ENT-1:0] inst_oh_i
);
  a_r1_req_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> $past(st_valid_i && st_ready_o));
  a_r3_nodata_after_coh_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nodata_o |-> $past(st_valid_i && st_ready_o && st_coh_i && !st_hit_sr_i));
  a_r6_inv_with_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> (req_valid_o && req_kill_o && req_line_o == inv_line_o));
  a_r7_wr_modified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> wr_state_o == 2'b11);
  a_r9_stall_only_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_ready_o |-> busy_i != '0);
  a_r11_one_install: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inst_oh_i) && ((inst_oh_i & ~busy_i) == '0));
endmodule

bind stmerge_rlb stmerge_rlb_chk #(.N_ENT(N_ENT), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st_valid_i  (st_valid_i),
  .st_ready_o  (st_ready_o),
  .st_coh_i    (st_coh_i),
  .st_hit_sr_i (st_hit_sr_i),
  .req_valid_o (req_valid_o),
  .req_kill_o  (req_kill_o),
  .req_line_o  (req_line_o),
  .inv_valid_o (inv_valid_o),
  .inv_line_o  (inv_line_o),
  .nodata_o    (nodata_o),
  .wr_valid_o  (wr_valid_o),
  .wr_state_o  (wr_state_o),
  .busy_i      (busy),
  .inst_oh_i   (inst_oh)
);

// File: tb/sim_stmerge_rlb.sv
`timescale 1ns/1ps
module sim_stmerge_rlb;
  localparam int LB = 32;
  localparam int DW = 256;
  localparam int AW = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          st_valid = 0, st_ready, st_coh = 0, st_hit = 0;
  logic [AW-1:0] st_line = '0;
  logic [LB-1:0] st_be = '0;
  logic [DW-1:0] st_data = '0, st_old = '0;
  logic          req_valid, req_kill, inv_valid, nodata;
  logic [AW-1:0] req_line, inv_line, wr_line;
  logic [1:0]    req_id, nodata_id, wr_state;
  logic          fill_valid = 0, kill_done = 0, wr_valid;
  logic [1:0]    fill_id = '0, kill_id = '0;
  logic [DW-1:0] fill_data = '0, wr_data;

  stmerge_rlb u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_line_i(st_line),
    .st_be_i(st_be), .st_data_i(st_data), .st_coh_i(st_coh),
    .st_hit_sr_i(st_hit), .st_old_i(st_old),
    .req_valid_o(req_valid), .req_kill_o(req_kill), .req_line_o(req_line),
    .req_id_o(req_id), .inv_valid_o(inv_valid), .inv_line_o(inv_line),
    .nodata_o(nodata), .nodata_id_o(nodata_id),
    .fill_valid_i(fill_valid), .fill_id_i(fill_id), .fill_data_i(fill_data),
    .kill_done_i(kill_done), .kill_id_i(kill_id),
    .wr_valid_o(wr_valid), .wr_line_o(wr_line), .wr_data_o(wr_data),
    .wr_state_o(wr_state)
  );

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_line_q [$];
  logic [DW-1:0] exp_data_q [$];

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mrg(input logic [DW-1:0] base, input logic [LB-1:0] be,
                                        input logic [DW-1:0] d);
    logic [DW-1:0] r = base;
    for (int b = 0; b < LB; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] keep(input logic [LB-1:0] be, input logic [DW-1:0] d);
    return mrg('0, be, d);
  endfunction

  task automatic expect_wr(input logic [AW-1:0] l, input logic [DW-1:0] d);
    exp_line_q.push_back(l);
    exp_data_q.push_back(d);
  endtask

  // monitor: every write-back is matched against the scoreboard
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_line_q.size() == 0) begin
        chk(1'b0, "R11 unexpected write-back", DW'(wr_line), '0);
      end else begin
        logic [AW-1:0] el;
        logic [DW-1:0] ed;
        el = exp_line_q.pop_front();
        ed = exp_data_q.pop_front();
        chk(wr_line == el, "R11 write-back line order", DW'(wr_line), DW'(el));
        chk(wr_data == ed, "R2 write-back data", wr_data, ed);
        chk(wr_state == 2'b11, "R7 write-back state modified", DW'(wr_state), DW'(2'b11));
      end
    end
  end

  task automatic store(input logic [AW-1:0] l, input logic [LB-1:0] be, input logic [DW-1:0] d,
                       input bit coh, input bit hit, input logic [DW-1:0] old);
    bit r;
    @(posedge clk); #1;
    st_valid = 1; st_line = l; st_be = be; st_data = d; st_coh = coh; st_hit = hit; st_old = old;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk); r = st_ready;
      @(posedge clk);
      if (r) break;
    end
    #1 st_valid = 0;
  endtask

  task automatic resp(input bit f, input logic [1:0] fid, input logic [DW-1:0] fd,
                      input bit k, input logic [1:0] kid);
    @(posedge clk); #1;
    fill_valid = f; fill_id = fid; fill_data = fd; kill_done = k; kill_id = kid;
    @(posedge clk); #1;
    fill_valid = 0; kill_done = 0;
  endtask

  localparam logic [LB-1:0] LO16 = 32'h0000_FFFF;
  localparam logic [LB-1:0] HI16 = 32'hFFFF_0000;

  initial begin : watchdog
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] d1, d2, fd, od, ex;
    logic [1:0] id, id0, id1, id2, id3, id4;
    bit r;
    d1 = {8{32'hA1B2C3D4}};
    d2 = {8{32'h55667788}};
    fd = {8{32'hF0F1F2F3}};
    od = {8{32'h0BADCAFE}};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(st_ready == 1 && req_valid == 0 && wr_valid == 0 && nodata == 0, "R1 reset state",
        DW'({st_ready, req_valid, wr_valid, nodata}), DW'(4'b1000));

    // non-coherent miss, two halves
    store(26'h100, LO16, d1, 0, 0, '0);
    chk(req_valid && !req_kill && req_line == 26'h100 && req_id == 2'd0, "R1 read request",
        DW'({req_valid, req_kill, req_line, req_id}), DW'({1'b1, 1'b0, 26'h100, 2'd0}));
    expect_wr(26'h100, mrg(keep(LO16, d1), HI16, d2));
    store(26'h100, HI16, d2, 0, 0, '0);
    chk(!req_valid, "R2 merge raises no request", DW'(req_valid), '0);
    chk(wr_valid && !nodata, "R4 non-coherent full line installs at once",
        DW'({wr_valid, nodata}), DW'(2'b10));
    chk(wr_line == 26'h100, "R5 two halves complete line", DW'(wr_line), DW'(26'h100));

    // coherent miss, two halves
    store(26'h200, LO16, d2, 1, 0, '0);
    id = req_id;
    store(26'h200, HI16, d1, 1, 0, '0);
    chk(nodata && nodata_id == id, "R3 no-data pulse", DW'({nodata, nodata_id}), DW'({1'b1, id}));
    chk(!wr_valid, "R3 waits for response", DW'(wr_valid), '0);
    repeat (3) @(posedge clk);
    #1 chk(!wr_valid && !nodata, "R3 still waiting, single pulse", DW'({wr_valid, nodata}), '0);
    expect_wr(26'h200, mrg(keep(LO16, d2), HI16, d1));
    resp(0, '0, '0, 1, id);
    chk(wr_valid, "R3 installs after kill-done", DW'(wr_valid), DW'(1));

    // fill fills only unwritten bytes
    store(26'h300, 32'h0000_00FF, d1, 1, 0, '0);
    id = req_id;
    ex = mrg(fd, 32'h0000_00FF, d1);
    expect_wr(26'h300, ex);
    resp(1, id, fd, 0, '0);
    chk(wr_valid && wr_data == ex, "R8 fill merge under store bytes", wr_data, ex);

    // shared/recent hit upgrade
    store(26'h400, 32'h0000_0FF0, d2, 1, 1, od);
    id = req_id;
    chk(inv_valid && inv_line == 26'h400 && req_valid && req_kill, "R6 invalidate and kill",
        DW'({inv_valid, inv_line, req_valid, req_kill}), DW'({1'b1, 26'h400, 1'b1, 1'b1}));
    repeat (2) @(posedge clk);
    #1 chk(!wr_valid, "R7 upgrade waits for kill", DW'(wr_valid), '0);
    ex = mrg(od, 32'h0000_0FF0, d2);
    expect_wr(26'h400, ex);
    resp(0, '0, '0, 1, id);
    chk(wr_valid && wr_data == ex, "R6 old data under store bytes", wr_data, ex);
    @(posedge clk);

    // capacity
    store(26'h010, LO16, d1, 1, 0, '0); id0 = req_id;
    store(26'h011, 32'h0000_00F0, d1, 1, 0, '0); id1 = req_id;
    store(26'h012, LO16, d2, 1, 0, '0); id2 = req_id;
    store(26'h013, LO16, d1, 1, 0, '0); id3 = req_id;
    store(26'h012, HI16, d1, 1, 0, '0);
    chk(!req_valid && nodata && nodata_id == id2, "R2 merge while full",
        DW'({req_valid, nodata, nodata_id}), DW'({1'b0, 1'b1, id2}));
    @(posedge clk); #1;
    st_valid = 1; st_line = 26'h014; st_be = LO16; st_data = d2; st_coh = 1; st_hit = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!st_ready, "R9 fifth line stalls", DW'(st_ready), '0);
      @(posedge clk); #1;
    end
    expect_wr(26'h010, mrg(fd, LO16, d1));
    fill_valid = 1; fill_id = id0; fill_data = fd;
    @(posedge clk); #1 fill_valid = 0;
    r = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); r = st_ready;
      @(posedge clk);
      if (r) break;
    end
    #1 st_valid = 0;
    chk(r && req_valid && req_id == id0, "R9 stall released by free entry",
        DW'({r, req_valid, req_id}), DW'({1'b1, 1'b1, id0}));
    id4 = req_id;

    // two entries ready together
    expect_wr(26'h011, mrg(fd, 32'h0000_00F0, d1));
    expect_wr(26'h012, mrg(keep(LO16, d2), HI16, d1));
    @(posedge clk); #1;
    fill_valid = 1; fill_id = id1; fill_data = fd; kill_done = 1; kill_id = id2;
    @(posedge clk); #1 fill_valid = 0; kill_done = 0;
    chk(wr_valid && wr_line == 26'h011, "R11 lowest index first", DW'(wr_line), DW'(26'h011));
    @(posedge clk); #1;
    chk(wr_valid && wr_line == 26'h012, "R11 next entry next cycle", DW'(wr_line), DW'(26'h012));
    expect_wr(26'h013, mrg(fd, LO16, d1));
    resp(1, id3, fd, 0, '0);
    expect_wr(26'h014, mrg(fd, LO16, d2));
    resp(1, id4, fd, 0, '0);
    repeat (3) @(posedge clk);

    // responses to free entries
    #1 fill_valid = 1; fill_id = 2'd2; fill_data = fd; kill_done = 1; kill_id = 2'd1;
    @(posedge clk); #1 fill_valid = 0; kill_done = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!wr_valid, "R10 stray response ignored", DW'(wr_valid), '0);
    end
    repeat (2) @(posedge clk);
    chk(exp_line_q.size() == 0, "R11 all expected write-backs seen",
        DW'(exp_line_q.size()), '0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule